// File: doc/BRIEF.md
# NAND Flash Identification Probe

This block identifies an 8-bit NAND flash device. After reset, or whenever a probe is requested, it asks an external arbiter for the flash bus. Once the bus is granted it runs two read-ID transactions back to back. The first transaction uses ID address 00h and returns five bytes: maker code, device code and three geometry bytes. The second uses ID address 20h and returns four bytes that form the interface-standard signature.

From these bytes the block derives four results: the maker code, the device code, the page size and block size as log2 values that address logic can shift by directly, and a flag that shows whether the signature spells "ONFI". The results change only at the end of a complete probe, when a valid flag rises. Every command, address and read pulse goes through one strobe engine whose pulse widths are parameters. The same engine also times a programmable wait between the last address cycle and the first read pulse.

Top module: `nand_id_probe`

## Requirements
- R1: A probe starts on its own after reset is released, and a one-cycle `probe_req_i` pulse while idle starts a new probe.
- R2: `bus_req_o` is high from the cycle after a probe is accepted until the probe ends. While `bus_req_o` is low, or before `bus_gnt_i` is seen, no strobe or data drive occurs: `nand_we_no`=1, `nand_re_no`=1, `nand_cle_o`=0, `nand_ale_o`=0, `nand_dq_oe_o`=0.
- R3: The bus sequence is:
  1. command 90h, then address 00h, then five read pulses;
  2. command 90h, then address 20h, then four read pulses.

  A command cycle has `nand_cle_o`=1 and an address cycle has `nand_ale_o`=1. Each value is presented on `nand_dq_o` and is valid at the rising edge of `nand_we_no`.
- R4: At least `T_WHR` clock cycles separate the rising edge of `nand_we_no` for the last address cycle from the next falling edge of `nand_re_no`.
- R5: `maker_o` equals the first byte read at ID address 00h, and `device_o` equals the second.
- R6: `page_log2_o` = 10 + bits [1:0] of the fourth byte at ID address 00h. This gives 1, 2, 4 or 8 KiB.
- R7: `block_log2_o` = 16 + bits [5:4] of the fourth byte at ID address 00h. This gives 64, 128, 256 or 512 KiB.
- R8: `onfi_o` is 1 only if the four bytes at ID address 20h are 4Fh, 4Eh, 46h, 49h in that order.
- R9: `valid_o` falls one cycle after a probe is accepted. All result outputs keep their previous values during the probe. They update, and `valid_o` rises, on the clock edge 3 + S after acceptance with the grant present immediately, where S = 4(1+T_WP+T_WH) + 2(T_WHR+2) + 9(1+T_RP+T_REH). Each cycle of grant delay adds one cycle.
- R10: A `probe_req_i` pulse during a running probe is ignored. No second probe follows, and `valid_o` stays high afterwards.
- R11: During reset all strobes are inactive, `bus_req_o` is 0, `valid_o` is 0 and all results are 0.
- R12: Each `nand_we_no` low pulse lasts exactly `T_WP` cycles, and each `nand_re_no` low pulse lasts exactly `T_RP` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| probe_req_i | input | 1 | Request a new probe (pulse) |
| bus_req_o | output | 1 | Flash bus request to arbiter |
| bus_gnt_i | input | 1 | Flash bus grant from arbiter |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Command/address byte out |
| nand_dq_oe_o | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Data byte from flash |
| maker_o | output | 8 | Maker code |
| device_o | output | 8 | Device code |
| page_log2_o | output | 5 | log2 of page size in bytes |
| block_log2_o | output | 5 | log2 of block size in bytes |
| onfi_o | output | 1 | Signature matched "ONFI" |
| valid_o | output | 1 | Results valid |

## Verification
Results are due on a fixed clock edge: `valid_o` drops on the first edge after a request is accepted, and rises on edge 3 + S, plus one edge for each cycle the grant is withheld. The bench counts rising edges from the request and reads the outputs at the following falling edge, so each result is compared exactly at the cycle it falls due. Strobe pulse widths and the address-to-read gap are measured in whole cycles from edge timestamps of a flash model. The command and address log and the read count are compared after each probe.

// File: rtl/nand_id_pkg.sv
package nand_id_pkg;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WAIT, OP_READ} op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic [7:0]  data;
    logic [3:0]  slot;
  } bus_op_t;

  localparam logic [7:0]  CMD_READ_ID = 8'h90;
  localparam logic [7:0]  ADDR_ID     = 8'h00;
  localparam logic [7:0]  ADDR_SIG    = 8'h20;
  localparam logic [31:0] SIG_WORD    = 32'h4F4E_4649;

  localparam int ID_BYTES  = 5;
  localparam int SIG_BYTES = 4;
  localparam int GEO_IDX   = 3;
  localparam int STEPS_A   = 3 + ID_BYTES;
  localparam int NUM_STEPS = STEPS_A + 3 + SIG_BYTES;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  // step: cmd, addr, wait, reads... for each of the two probes
  function automatic bus_op_t step_op(input logic [STEP_W-1:0] idx);
    bus_op_t op;
    logic    second;
    int      loc;
    second  = (int'(idx) >= STEPS_A);
    loc     = second ? int'(idx) - STEPS_A : int'(idx);
    op.kind = OP_WAIT;
    op.data = 8'h00;
    op.slot = 4'd0;
    case (loc)
      0: begin op.kind = OP_CMD;  op.data = CMD_READ_ID; end
      1: begin op.kind = OP_ADDR; op.data = second ? ADDR_SIG : ADDR_ID; end
      2: op.kind = OP_WAIT;
      default: begin
        op.kind = OP_READ;
        op.slot = 4'(second ? ID_BYTES + loc - 3 : loc - 3);
      end
    endcase
    return op;
  endfunction

endpackage

// File: rtl/nand_bus_phy.sv
module nand_bus_phy
  import nand_id_pkg::*;
#(
  parameter int T_WP  = 2,
  parameter int T_WH  = 2,
  parameter int T_RP  = 2,
  parameter int T_REH = 2,
  parameter int T_WHR = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       op_valid_i,
  input  op_kind_e   op_kind_i,
  input  logic [7:0] op_data_i,
  output logic       op_done_o,
  output logic [7:0] rd_data_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] dq_o,
  output logic       dq_oe_o,
  input  logic [7:0] dq_i
);

  localparam int MAX_A = (T_WP > T_WH) ? T_WP : T_WH;
  localparam int MAX_B = (T_RP > T_REH) ? T_RP : T_REH;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > T_WHR) ? MAX_C : T_WHR;
  localparam int CNT_W = $clog2(MAX_T + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;

  ph_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  op_kind_e         kind_q;
  logic [7:0]       data_q;
  logic [7:0]       rd_q;
  logic             is_wr;

  function automatic logic [CNT_W-1:0] low_len(input op_kind_e k);
    case (k)
      OP_CMD, OP_ADDR: return CNT_W'(T_WP - 1);
      OP_READ:         return CNT_W'(T_RP - 1);
      default:         return CNT_W'(T_WHR - 1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] high_len(input op_kind_e k);
    case (k)
      OP_CMD, OP_ADDR: return CNT_W'(T_WH - 1);
      OP_READ:         return CNT_W'(T_REH - 1);
      default:         return '0;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= OP_WAIT;
      data_q <= '0;
      rd_q   <= '0;
    end else begin
      case (st_q)
        PH_IDLE: if (op_valid_i) begin
          st_q   <= PH_LOW;
          kind_q <= op_kind_i;
          data_q <= op_data_i;
          cnt_q  <= low_len(op_kind_i);
        end
        PH_LOW: if (cnt_q == '0) begin
          st_q  <= PH_HIGH;
          cnt_q <= high_len(kind_q);
          if (kind_q == OP_READ) rd_q <= dq_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        PH_HIGH: if (cnt_q == '0) st_q <= PH_IDLE;
                 else cnt_q <= cnt_q - 1'b1;
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign is_wr     = (kind_q == OP_CMD) || (kind_q == OP_ADDR);
  assign op_done_o = (st_q == PH_HIGH) && (cnt_q == '0);
  assign rd_data_o = rd_q;
  assign we_no     = !((st_q == PH_LOW) && is_wr);
  assign re_no     = !((st_q == PH_LOW) && (kind_q == OP_READ));
  assign cle_o     = (st_q != PH_IDLE) && (kind_q == OP_CMD);
  assign ale_o     = (st_q != PH_IDLE) && (kind_q == OP_ADDR);
  assign dq_oe_o   = (st_q != PH_IDLE) && is_wr;
  assign dq_o      = dq_oe_o ? data_q : 8'h00;

  // pulse width monitors
  logic [CNT_W:0] we_low_q, re_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_q <= '0;
      re_low_q <= '0;
    end else begin
      we_low_q <= we_no ? '0 : we_low_q + 1'b1;
      re_low_q <= re_no ? '0 : re_low_q + 1'b1;
    end
  end

  p_cle_ale_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_we_width_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> we_low_q == (CNT_W+1)'(T_WP));
  p_re_width_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(re_no) |-> re_low_q == (CNT_W+1)'(T_RP));

endmodule

// File: rtl/nand_id_seq.sv
module nand_id_seq
  import nand_id_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       probe_req_i,
  input  logic       bus_gnt_i,
  output logic       bus_req_o,
  output logic       op_valid_o,
  output op_kind_e   op_kind_o,
  output logic [7:0] op_data_o,
  input  logic       op_done_i,
  output logic       cap_en_o,
  output logic [3:0] cap_slot_o,
  output logic       clear_o,
  output logic       commit_o
);

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_RUN, SQ_DONE} sq_e;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  sq_e               st_q;
  logic              pend_q;
  logic [STEP_W-1:0] step_q;
  logic              go;
  bus_op_t           cur;

  assign go  = pend_q || probe_req_i;
  assign cur = step_op(step_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      pend_q <= 1'b1;   // probe once out of reset
      step_q <= '0;
    end else begin
      case (st_q)
        SQ_IDLE: if (go) begin
          st_q   <= SQ_REQ;
          pend_q <= 1'b0;
        end
        SQ_REQ: if (bus_gnt_i) st_q <= SQ_RUN;
        SQ_RUN: if (op_done_i) begin
          if (step_q == LAST_STEP) begin
            step_q <= '0;
            st_q   <= SQ_DONE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_req_o  = (st_q == SQ_REQ) || (st_q == SQ_RUN);
  assign op_valid_o = (st_q == SQ_RUN);
  assign op_kind_o  = cur.kind;
  assign op_data_o  = cur.data;
  assign cap_en_o   = (st_q == SQ_RUN) && op_done_i && (cur.kind == OP_READ);
  assign cap_slot_o = cur.slot;
  assign clear_o    = (st_q == SQ_IDLE) && go;
  assign commit_o   = (st_q == SQ_DONE);

  p_ignore_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_RUN && !op_done_i) |=> (st_q == SQ_RUN));

endmodule

// File: rtl/nand_id_decode.sv
module nand_id_decode
  import nand_id_pkg::*;
#(
  parameter int LOG2_W          = 5,
  parameter int PAGE_BASE_LOG2  = 10,
  parameter int BLOCK_BASE_LOG2 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_en_i,
  input  logic [3:0]        cap_slot_i,
  input  logic [7:0]        cap_data_i,
  input  logic              commit_i,
  output logic [7:0]        maker_o,
  output logic [7:0]        device_o,
  output logic [LOG2_W-1:0] page_log2_o,
  output logic [LOG2_W-1:0] block_log2_o,
  output logic              onfi_o,
  output logic              valid_o
);

  logic [7:0]           maker_n, device_n;
  logic [1:0]           page_f, block_f;
  logic [SIG_BYTES-1:0] sig_sel, sig_eq, hit_q;

  // signature checked byte by byte as it arrives
  for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
    assign sig_sel[g] = cap_en_i && (cap_slot_i == 4'(ID_BYTES + g));
    assign sig_eq[g]  = cap_data_i == SIG_WORD[8*(SIG_BYTES-1-g) +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maker_n  <= '0;
      device_n <= '0;
      page_f   <= '0;
      block_f  <= '0;
      hit_q    <= '0;
    end else begin
      if (cap_en_i && cap_slot_i == 4'd0)           maker_n  <= cap_data_i;
      if (cap_en_i && cap_slot_i == 4'd1)           device_n <= cap_data_i;
      if (cap_en_i && cap_slot_i == 4'(GEO_IDX)) begin
        page_f  <= cap_data_i[1:0];
        block_f <= cap_data_i[5:4];
      end
      for (int i = 0; i < SIG_BYTES; i++)
        if (sig_sel[i]) hit_q[i] <= sig_eq[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maker_o      <= '0;
      device_o     <= '0;
      page_log2_o  <= '0;
      block_log2_o <= '0;
      onfi_o       <= 1'b0;
      valid_o      <= 1'b0;
    end else if (commit_i) begin
      maker_o      <= maker_n;
      device_o     <= device_n;
      page_log2_o  <= LOG2_W'(PAGE_BASE_LOG2) + LOG2_W'(page_f);
      block_log2_o <= LOG2_W'(BLOCK_BASE_LOG2) + LOG2_W'(block_f);
      onfi_o       <= &hit_q;
      valid_o      <= 1'b1;
    end else if (clear_i) begin
      valid_o <= 1'b0;
    end
  end

  p_hold_results_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(maker_o) && $stable(device_o) && $stable(page_log2_o)
                  && $stable(block_log2_o) && $stable(onfi_o));
  p_valid_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> valid_o);
  p_valid_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !commit_i) |=> !valid_o);

endmodule

// File: rtl/nand_id_probe.sv
module nand_id_probe
  import nand_id_pkg::*;
#(
  parameter int T_WP            = 2,
  parameter int T_WH            = 2,
  parameter int T_RP            = 2,
  parameter int T_REH           = 2,
  parameter int T_WHR           = 6,
  parameter int LOG2_W          = 5,
  parameter int PAGE_BASE_LOG2  = 10,
  parameter int BLOCK_BASE_LOG2 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              probe_req_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [7:0]        nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [7:0]        nand_dq_i,
  output logic [7:0]        maker_o,
  output logic [7:0]        device_o,
  output logic [LOG2_W-1:0] page_log2_o,
  output logic [LOG2_W-1:0] block_log2_o,
  output logic              onfi_o,
  output logic              valid_o
);

  logic       op_valid, op_done, cap_en, clear, commit;
  op_kind_e   op_kind;
  logic [7:0] op_data, rd_data;
  logic [3:0] cap_slot;

  nand_id_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .probe_req_i(probe_req_i),
    .bus_gnt_i  (bus_gnt_i),
    .bus_req_o  (bus_req_o),
    .op_valid_o (op_valid),
    .op_kind_o  (op_kind),
    .op_data_o  (op_data),
    .op_done_i  (op_done),
    .cap_en_o   (cap_en),
    .cap_slot_o (cap_slot),
    .clear_o    (clear),
    .commit_o   (commit)
  );

  nand_bus_phy #(
    .T_WP(T_WP), .T_WH(T_WH), .T_RP(T_RP), .T_REH(T_REH), .T_WHR(T_WHR)
  ) u_phy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_valid_i(op_valid),
    .op_kind_i (op_kind),
    .op_data_i (op_data),
    .op_done_o (op_done),
    .rd_data_o (rd_data),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_no     (nand_we_no),
    .re_no     (nand_re_no),
    .dq_o      (nand_dq_o),
    .dq_oe_o   (nand_dq_oe_o),
    .dq_i      (nand_dq_i)
  );

  nand_id_decode #(
    .LOG2_W(LOG2_W), .PAGE_BASE_LOG2(PAGE_BASE_LOG2), .BLOCK_BASE_LOG2(BLOCK_BASE_LOG2)
  ) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .cap_en_i    (cap_en),
    .cap_slot_i  (cap_slot),
    .cap_data_i  (rd_data),
    .commit_i    (commit),
    .maker_o     (maker_o),
    .device_o    (device_o),
    .page_log2_o (page_log2_o),
    .block_log2_o(block_log2_o),
    .onfi_o      (onfi_o),
    .valid_o     (valid_o)
  );

  // address-to-read gap monitor
  localparam int GAP_W = $clog2(T_WHR + 2) + 1;
  logic [GAP_W-1:0] gap_q;
  logic             armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else if (nand_ale_o) begin
      gap_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (gap_q != '1) gap_q <= gap_q + 1'b1;
      if (!nand_re_no) armed_q <= 1'b0;
    end
  end

  p_whr_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(nand_re_no) && armed_q) |-> gap_q >= GAP_W'(T_WHR));
  p_bus_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> (nand_we_no && nand_re_no && !nand_cle_o && !nand_ale_o && !nand_dq_oe_o));

endmodule

// File: tb/nand_id_probe_tb.sv
`timescale 1ns/1ps
module nand_id_probe_tb;

  localparam int T_WP = 2, T_WH = 2, T_RP = 2, T_REH = 2, T_WHR = 6;
  localparam int OP_WR = 1 + T_WP + T_WH;
  localparam int OP_RD = 1 + T_RP + T_REH;
  localparam int OP_WT = T_WHR + 2;
  localparam int SPAN  = 4*OP_WR + 2*OP_WT + 9*OP_RD;
  localparam int LAT   = 3 + SPAN;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       probe_req_i = 1'b0;
  logic       gnt_en = 1'b1;
  logic       bus_req_o, bus_gnt_i;
  logic       nand_cle_o, nand_ale_o, nand_we_no, nand_re_no, nand_dq_oe_o;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic [7:0] maker_o, device_o;
  logic [4:0] page_log2_o, block_log2_o;
  logic       onfi_o, valid_o;

  int n_checks = 0;
  int n_err    = 0;

  always #10 clk_i = ~clk_i;
  assign bus_gnt_i = bus_req_o & gnt_en;

  nand_id_probe #(.T_WP(T_WP), .T_WH(T_WH), .T_RP(T_RP), .T_REH(T_REH), .T_WHR(T_WHR)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .probe_req_i(probe_req_i),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i),
    .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o), .nand_we_no(nand_we_no),
    .nand_re_no(nand_re_no), .nand_dq_o(nand_dq_o), .nand_dq_oe_o(nand_dq_oe_o),
    .nand_dq_i(nand_dq_i), .maker_o(maker_o), .device_o(device_o),
    .page_log2_o(page_log2_o), .block_log2_o(block_log2_o),
    .onfi_o(onfi_o), .valid_o(valid_o)
  );

  // flash model
  logic [7:0] id_mem [5];
  logic [7:0] sig_mem [4];
  logic [7:0] last_addr = 8'h00;
  int         rd_ptr = 0, rd_total = 0, wr_cnt = 0, cyc = 0;
  logic [8:0] wr_log [8];
  int         we_fall = 0, re_fall = 0, addr_rise = 0;
  int         width_bad = 0, whr_bad = 0;
  bit         after_addr = 0;

  always @(posedge clk_i) cyc++;

  assign nand_dq_i = (last_addr == 8'h20) ? ((rd_ptr < 4) ? sig_mem[rd_ptr] : 8'hFF)
                                          : ((rd_ptr < 5) ? id_mem[rd_ptr] : 8'hFF);

  always @(negedge nand_we_no) if (rst_ni === 1'b1) we_fall = cyc;
  always @(posedge nand_we_no) if (rst_ni === 1'b1) begin
    if (cyc - we_fall != T_WP) width_bad++;
    if (wr_cnt < 8) wr_log[wr_cnt] = {nand_cle_o, nand_dq_o};
    wr_cnt++;
    if (nand_ale_o) begin
      last_addr = nand_dq_o; rd_ptr = 0; addr_rise = cyc; after_addr = 1;
    end
  end
  always @(negedge nand_re_no) if (rst_ni === 1'b1) begin
    re_fall = cyc;
    if (after_addr && (cyc - addr_rise < T_WHR)) whr_bad++;
    after_addr = 0;
  end
  always @(posedge nand_re_no) if (rst_ni === 1'b1) begin
    if (cyc - re_fall != T_RP) width_bad++;
    rd_ptr++; rd_total++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_dev(input logic [39:0] id, input logic [31:0] sig);
    for (int i = 0; i < 5; i++) id_mem[i] = id[8*(4-i) +: 8];
    for (int i = 0; i < 4; i++) sig_mem[i] = sig[8*(3-i) +: 8];
  endtask

  task automatic clear_logs();
    wr_cnt = 0; rd_total = 0; width_bad = 0; whr_bad = 0;
  endtask

  // runs one probe; counts edges from acceptance until valid_o is high
  task automatic run_probe(input bit by_reset, input int gnt_at, input int busy_at,
                           output int n);
    logic [7:0] m0, d0;
    logic [4:0] p0, b0;
    logic       o0;
    m0 = maker_o; d0 = device_o; p0 = page_log2_o; b0 = block_log2_o; o0 = onfi_o;
    n = 0;
    clear_logs();
    if (gnt_at > 0) gnt_en = 1'b0;
    @(negedge clk_i);
    if (by_reset) rst_ni = 1'b1; else probe_req_i = 1'b1;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i); probe_req_i = 1'b0;
      if (n == 1) check("R9 valid low after accept", valid_o, 0);
      if (gnt_at > 0 && n == gnt_at - 1) begin
        check("R2 request while waiting", bus_req_o, 1);
        check("R2 bus quiet before grant",
              {nand_we_no, nand_re_no, nand_cle_o, nand_ale_o, nand_dq_oe_o}, 5'b11000);
      end
      if (n == gnt_at) gnt_en = 1'b1;
      if (n == busy_at) probe_req_i = 1'b1;
      if (n == 20) check("R9 results held mid-probe",
                         {maker_o, device_o, p0 ^ page_log2_o, b0 ^ block_log2_o, onfi_o},
                         {m0, d0, 5'd0, 5'd0, o0});
    end while (!valid_o && n < 5000);
  endtask

  task automatic check_bus(input string tag);
    check({"R3 write count ", tag}, wr_cnt, 4);
    check({"R3 cmd1 ", tag},  wr_log[0], 9'h190);
    check({"R3 addr1 ", tag}, wr_log[1], 9'h000);
    check({"R3 cmd2 ", tag},  wr_log[2], 9'h190);
    check({"R3 addr2 ", tag}, wr_log[3], 9'h020);
    check({"R3 read count ", tag}, rd_total, 9);
    check({"R4 tWHR gap ", tag}, whr_bad, 0);
    check({"R12 pulse widths ", tag}, width_bad, 0);
    check({"R2 request released ", tag}, bus_req_o, 0);
  endtask

  task automatic t_reset();
    load_dev(40'hEC_DC_10_95_54, 32'h4F4E4649);
    repeat (3) @(negedge clk_i);
    check("R11 strobes idle in reset",
          {nand_we_no, nand_re_no, nand_cle_o, nand_ale_o, nand_dq_oe_o}, 5'b11000);
    check("R11 no request in reset", bus_req_o, 0);
    check("R11 results zero in reset",
          {valid_o, onfi_o, maker_o, device_o, page_log2_o, block_log2_o}, 0);
  endtask

  task automatic t_auto_probe();
    int n;
    run_probe(1'b1, 0, 0, n);
    check("R1 R9 auto probe latency", n, LAT);
    check("R5 maker", maker_o, 8'hEC);
    check("R5 device", device_o, 8'hDC);
    check("R6 page log2 (2 KiB)", page_log2_o, 11);
    check("R7 block log2 (128 KiB)", block_log2_o, 17);
    check("R8 signature match", onfi_o, 1);
    check_bus("auto");
  endtask

  task automatic t_request_busy();
    int n;
    load_dev(40'h98_D3_90_33_76, 32'h4E4F4649);   // "NOFI": wrong order
    run_probe(1'b0, 0, 30, n);
    check("R1 R9 request latency", n, LAT);
    check("R5 maker B", maker_o, 8'h98);
    check("R5 device B", device_o, 8'hD3);
    check("R6 page log2 (8 KiB)", page_log2_o, 13);
    check("R7 block log2 (512 KiB)", block_log2_o, 19);
    check("R8 reordered signature", onfi_o, 0);
    check_bus("busy");
    repeat (40) @(negedge clk_i);
    check("R10 no second probe", {bus_req_o, valid_o}, 2'b01);
    check("R10 results kept", maker_o, 8'h98);
  endtask

  task automatic t_grant_delay();
    int n;
    load_dev(40'h2C_68_00_00_11, 32'h4F4E4658);   // "ONFX"
    run_probe(1'b0, 10, 0, n);
    check("R2 R9 latency with grant delay", n, LAT + 9);
    check("R6 page log2 (1 KiB)", page_log2_o, 10);
    check("R7 block log2 (64 KiB)", block_log2_o, 16);
    check("R8 last byte mismatch", onfi_o, 0);
    check("R5 maker C", maker_o, 8'h2C);
    check_bus("grant");
  endtask

  task automatic t_mixed_fields();
    int n;
    load_dev(40'hAD_F1_80_21_00, 32'h4F4E4649);
    run_probe(1'b0, 0, 0, n);
    check("R9 latency D", n, LAT);
    check("R6 page log2 field 01", page_log2_o, 11);
    check("R7 block log2 field 10", block_log2_o, 18);
    check("R8 signature match again", onfi_o, 1);
    check("R5 device D", device_o, 8'hF1);
  endtask

  initial begin
    t_reset();
    t_auto_probe();
    t_request_busy();
    t_grant_delay();
    t_mixed_fields();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule